// File: doc/BRIEF.md
# SD Card Single-Line Data Path Controller

This block moves data between a byte-wide FIFO and the one-bit data line of an SD/MMC card. It runs at one line bit per clock. A one-cycle `start` pulse, given while the block is idle, launches a transfer. The pulse captures the total byte count. The direction, block/stream selection, block length and timeout period are read from their inputs while the transfer runs, so they must be held stable until it ends.

When sending, the block takes bytes from a show-ahead FIFO and shifts them out most significant bit first, behind a start bit. In block mode it closes every block with a CRC16 and an end bit. It then reads the card's CRC status token and waits for the busy indication to clear. When receiving, it waits for the card's start bit and packs the incoming bits into bytes, which it writes to the FIFO. In block mode it also checks the CRC16 that follows each block. A data timer runs only while the block waits for receive data or for the card's busy to clear. Three sticky flags report timeout, CRC failure and FIFO error. All three are cleared by the next `start`.

Top module: `sd_data_path`

## Requirements
- R1: After reset, and whenever idle, `active`=0, `dat_oe`=0, `dat_out`=1, and the FIFO strobes are low. A `start` pulse while idle sets `active` on the next cycle and clears all three flags.
- R2: In receive mode (`dir_rx`=1) the block waits for a 0 on `dat_in` as the start bit, and the first data bit follows on the next cycle. A transfer whose remaining byte count is zero returns to idle.
- R3: Received bits are packed MSB first. On the cycle the eighth bit of a byte is on `dat_in`, `fifo_wr` pulses and `fifo_wr_data` carries the complete byte.
- R4: In receive block mode, the 16 CRC bits (sent MSB first) follow each block of `blk_len` bytes. A match resumes waiting for the next block. A mismatch sets `crc_fail` and ends the transfer.
- R5: In receive stream mode (`stream_mode`=1) there is one start bit and no CRC. Bytes arrive back to back until `data_len` bytes have been counted, and the block then goes idle.
- R6: If `fifo_full` is high when a received byte completes, the byte is not written, `fifo_err` is set, and the block returns to waiting for a start bit (idle if no bytes remain).
- R7: In send mode the block spends at least two cycles in its pre-send wait. It stays there while `fifo_empty` is high, and its first driven bit follows the cycle after the FIFO becomes non-empty.
- R8: A sent block is one 0 start bit, `blk_len` bytes MSB first, the CRC16 of those bytes MSB first, and one 1 end bit. The CRC16 uses polynomial x^16+x^12+x^5+1 with zero initial value. `dat_oe` is high exactly while these bits are driven.
- R9: In send stream mode there is one start bit and no CRC or end bit. Sending stops at a byte boundary after `data_len` bytes, or after the current byte if `enable` is low.
- R10: If another byte is needed at a byte boundary while `fifo_empty` is high, `fifo_err` is set and the block goes idle. The block never pulses `fifo_rd` while `fifo_empty` is high.
- R11: After a sent block, the card's status token is a 0, three bits and a 1. Bits 010 mean accepted: the block then waits for `dat_in`=1 (busy released) and continues with the next block or goes idle. Any other three bits set `crc_fail` and end the transfer.
- R12: The data timer counts only while waiting for a receive start bit or while waiting after a sent block. After `timeout_val` cycles in such a wait, `timeout_flag` is set and the block goes idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one line bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, honoured while idle |
| dir_rx | input | 1 | 1 = card to FIFO, 0 = FIFO to card |
| stream_mode | input | 1 | 1 = stream, 0 = block |
| enable | input | 1 | Send stream continues while high |
| blk_len | input | BLK_W | Bytes per block |
| data_len | input | LEN_W | Total bytes, captured at start |
| timeout_val | input | TMR_W | Data timer period in cycles |
| fifo_rd_data | input | 8 | Head byte of the send FIFO (show-ahead) |
| fifo_empty | input | 1 | Send FIFO empty |
| fifo_rd | output | 1 | Pop the send FIFO |
| fifo_wr | output | 1 | Push a received byte |
| fifo_wr_data | output | 8 | Received byte |
| fifo_full | input | 1 | Receive FIFO full |
| dat_in | input | 1 | Data line as seen from the card |
| dat_out | output | 1 | Driven data line value, 1 when released |
| dat_oe | output | 1 | Data line output enable |
| active | output | 1 | Transfer in progress |
| timeout_flag | output | 1 | Sticky data timeout |
| crc_fail | output | 1 | Sticky CRC or status-token failure |
| fifo_err | output | 1 | Sticky overrun or underrun |

## Verification
A `start` taken at one edge changes `active` at that edge. The first driven start bit appears two edges later when the FIFO already holds data. A timeout appears exactly `timeout_val` edges after the wait begins, so the bench counts negedges from the start pulse and checks `dat_oe` and `active` on both sides of each boundary. Received bytes are written on the edge that samples their eighth bit, and sent bits change just after each edge. The bench therefore drives `dat_in` and samples `dat_out` only on falling edges, and compares whole captured bit strings against frames with CRC16 computed in the bench.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WAIT_R, ST_RECV, ST_WAIT_S, ST_SEND, ST_BUSY
    } st_e;

    typedef enum logic [1:0] {PH_START, PH_DATA, PH_CRC, PH_END} ph_e;

    typedef enum logic [1:0] {TK_HUNT, TK_BITS, TK_END, TK_HOLD} tk_e;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [2:0]  TOKEN_OK = 3'b010;

    function automatic logic [15:0] crc16_step(logic [15:0] c, logic b);
        return {c[14:0], 1'b0} ^ ((c[15] ^ b) ? CRC_POLY : 16'h0000);
    endfunction

endpackage

// File: rtl/sdd_crc16.sv
module sdd_crc16 (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic        din,
    output logic [15:0] crc_q,
    output logic [15:0] crc_nxt
);
    assign crc_nxt = sdd_pkg::crc16_step(crc_q, din);

    always_ff @(posedge clk) begin
        if (rst || clr) crc_q <= '0;
        else if (en)    crc_q <= crc_nxt;
    end
endmodule

// File: rtl/sdd_data_timer.sv
module sdd_data_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] period,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + W'(1);
    end

    assign expired = run && (({1'b0, cnt} + (W+1)'(1)) >= {1'b0, period});
endmodule

// File: rtl/sd_data_path.sv
module sd_data_path
    import sdd_pkg::*;
#(
    parameter int BLK_W = 12,
    parameter int LEN_W = 16,
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             dir_rx,
    input  logic             stream_mode,
    input  logic             enable,
    input  logic [BLK_W-1:0] blk_len,
    input  logic [LEN_W-1:0] data_len,
    input  logic [TMR_W-1:0] timeout_val,
    input  logic [7:0]       fifo_rd_data,
    input  logic             fifo_empty,
    output logic             fifo_rd,
    output logic             fifo_wr,
    output logic [7:0]       fifo_wr_data,
    input  logic             fifo_full,
    input  logic             dat_in,
    output logic             dat_out,
    output logic             dat_oe,
    output logic             active,
    output logic             timeout_flag,
    output logic             crc_fail,
    output logic             fifo_err
);
    st_e              state;
    ph_e              phase;
    tk_e              tok_ph;
    logic [3:0]       bit_cnt;
    logic [7:0]       shreg;
    logic [LEN_W-1:0] data_cnt;
    logic [BLK_W-1:0] blk_cnt;
    logic             ws_done;
    logic [1:0]       tok;
    logic [15:0]      crc_q, crc_nxt;
    logic             expired;

    logic in_send, in_recv, byte_end, crc_end, blk_last, data_last, tx_more, tx_need;
    logic crc_clr, crc_en, crc_din, tmr_run;

    assign in_send   = (state == ST_SEND);
    assign in_recv   = (state == ST_RECV);
    assign byte_end  = (phase == PH_DATA) && (bit_cnt == 4'd7);
    assign crc_end   = (phase == PH_CRC) && (bit_cnt == 4'd15);
    assign blk_last  = (blk_cnt == BLK_W'(1));
    assign data_last = (data_cnt == LEN_W'(1));
    assign tx_more   = stream_mode ? (!data_last && enable) : !blk_last;
    assign tx_need   = in_send && ((phase == PH_START) || (byte_end && tx_more));

    assign fifo_rd      = tx_need && !fifo_empty;
    assign fifo_wr      = in_recv && byte_end && !fifo_full;
    assign fifo_wr_data = {shreg[6:0], dat_in};
    assign dat_oe       = in_send;
    assign active       = (state != ST_IDLE);

    always_comb begin
        dat_out = 1'b1;
        if (in_send) begin
            case (phase)
                PH_START: dat_out = 1'b0;
                PH_DATA:  dat_out = shreg[7];
                PH_CRC:   dat_out = crc_q[15];
                default:  dat_out = 1'b1;
            endcase
        end
    end

    assign crc_clr = !(in_recv || in_send) || (phase == PH_START);
    assign crc_en  = (in_recv || in_send) && ((phase == PH_DATA) || (phase == PH_CRC));
    assign crc_din = in_send ? dat_out : dat_in;
    assign tmr_run = (state == ST_WAIT_R) || (state == ST_BUSY);

    sdd_crc16 u_crc (
        .clk(clk), .rst(rst), .clr(crc_clr), .en(crc_en), .din(crc_din),
        .crc_q(crc_q), .crc_nxt(crc_nxt)
    );

    sdd_data_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst(rst), .run(tmr_run), .period(timeout_val), .expired(expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            phase        <= PH_START;
            tok_ph       <= TK_HUNT;
            bit_cnt      <= '0;
            shreg        <= '0;
            data_cnt     <= '0;
            blk_cnt      <= '0;
            ws_done      <= 1'b0;
            tok          <= '0;
            timeout_flag <= 1'b0;
            crc_fail     <= 1'b0;
            fifo_err     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    timeout_flag <= 1'b0;
                    crc_fail     <= 1'b0;
                    fifo_err     <= 1'b0;
                    data_cnt     <= data_len;
                    ws_done      <= 1'b0;
                    state        <= dir_rx ? ST_WAIT_R : ST_WAIT_S;
                end
                ST_WAIT_R: begin
                    if (data_cnt == '0) state <= ST_IDLE;
                    else if (!dat_in) begin
                        state   <= ST_RECV;
                        phase   <= PH_DATA;
                        bit_cnt <= '0;
                        blk_cnt <= blk_len;
                    end else if (expired) begin
                        timeout_flag <= 1'b1;
                        state        <= ST_IDLE;
                    end
                end
                ST_RECV: begin
                    bit_cnt <= bit_cnt + 4'd1;
                    if (phase == PH_DATA) begin
                        shreg <= {shreg[6:0], dat_in};
                        if (byte_end) begin
                            bit_cnt  <= '0;
                            data_cnt <= data_cnt - LEN_W'(1);
                            blk_cnt  <= blk_cnt - BLK_W'(1);
                            if (fifo_full) begin
                                fifo_err <= 1'b1;
                                state    <= ST_WAIT_R;
                            end else if (stream_mode) begin
                                if (data_last) state <= ST_WAIT_R;
                            end else if (blk_last) begin
                                phase <= PH_CRC;
                            end
                        end
                    end else if (crc_end) begin
                        if (crc_nxt == 16'h0000) state <= ST_WAIT_R;
                        else begin
                            crc_fail <= 1'b1;
                            state    <= ST_IDLE;
                        end
                    end
                end
                ST_WAIT_S: begin
                    ws_done <= 1'b1;
                    if (ws_done) begin
                        if (data_cnt == '0) state <= ST_IDLE;
                        else if (!fifo_empty) begin
                            state   <= ST_SEND;
                            phase   <= PH_START;
                            blk_cnt <= blk_len;
                        end
                    end
                end
                ST_SEND: begin
                    bit_cnt <= bit_cnt + 4'd1;
                    case (phase)
                        PH_START: begin
                            shreg   <= fifo_rd_data;
                            phase   <= PH_DATA;
                            bit_cnt <= '0;
                        end
                        PH_DATA: begin
                            shreg <= {shreg[6:0], 1'b0};
                            if (byte_end) begin
                                bit_cnt  <= '0;
                                data_cnt <= data_cnt - LEN_W'(1);
                                blk_cnt  <= blk_cnt - BLK_W'(1);
                                if (tx_more) begin
                                    if (fifo_empty) begin
                                        fifo_err <= 1'b1;
                                        state    <= ST_IDLE;
                                    end else shreg <= fifo_rd_data;
                                end else if (stream_mode) state <= ST_IDLE;
                                else phase <= PH_CRC;
                            end
                        end
                        PH_CRC: if (crc_end) phase <= PH_END;
                        default: begin
                            state  <= ST_BUSY;
                            tok_ph <= TK_HUNT;
                        end
                    endcase
                end
                ST_BUSY: begin
                    if (expired) begin
                        timeout_flag <= 1'b1;
                        state        <= ST_IDLE;
                    end else begin
                        case (tok_ph)
                            TK_HUNT: if (!dat_in) begin
                                tok_ph  <= TK_BITS;
                                bit_cnt <= '0;
                            end
                            TK_BITS: begin
                                tok     <= {tok[0], dat_in};
                                bit_cnt <= bit_cnt + 4'd1;
                                if (bit_cnt == 4'd2) begin
                                    if ({tok, dat_in} == TOKEN_OK) tok_ph <= TK_END;
                                    else begin
                                        crc_fail <= 1'b1;
                                        state    <= ST_IDLE;
                                    end
                                end
                            end
                            TK_END: tok_ph <= TK_HOLD;
                            default: if (dat_in) begin
                                state   <= ST_WAIT_S;
                                ws_done <= 1'b0;
                            end
                        endcase
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sd_data_path_chk.sv
module sd_data_path_chk
    import sdd_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic start,
    input logic active,
    input logic fifo_rd,
    input logic fifo_empty,
    input logic fifo_wr,
    input logic dat_oe,
    input logic timeout_flag,
    input logic crc_fail,
    input logic fifo_err,
    input st_e  state
);
    p_start_active_r1: assert property (@(posedge clk) disable iff (rst)
        (!active && start) |=> active);

    p_no_write_while_driving_r3: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> !dat_oe);

    p_crc_fail_source_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(crc_fail) |-> ($past(state) == ST_RECV || $past(state) == ST_BUSY));

    p_fifo_err_source_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(fifo_err) |-> ($past(state) == ST_RECV || $past(state) == ST_SEND));

    p_wait_two_cycles_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_S && $past(state) != ST_WAIT_S) |=> state == ST_WAIT_S);

    p_no_pop_empty_r10: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> !fifo_empty);

    p_timeout_source_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_flag) |-> ($past(state) == ST_WAIT_R || $past(state) == ST_BUSY));
endmodule

bind sd_data_path sd_data_path_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .active(active),
    .fifo_rd(fifo_rd), .fifo_empty(fifo_empty), .fifo_wr(fifo_wr),
    .dat_oe(dat_oe), .timeout_flag(timeout_flag), .crc_fail(crc_fail),
    .fifo_err(fifo_err), .state(state)
);

// File: tb/sd_data_path_bench.sv
`timescale 1ns/1ps
module sd_data_path_bench;
    logic clk = 0, rst = 1, start = 0, dir_rx = 0, stream_mode = 0, enable = 1;
    logic [11:0] blk_len = 12'd1;
    logic [15:0] data_len = 16'd1, timeout_val = 16'd100;
    logic fifo_full = 0, dat_in = 1;
    logic fifo_rd, fifo_wr, dat_out, dat_oe, active, timeout_flag, crc_fail, fifo_err, fifo_empty;
    logic [7:0] fifo_wr_data, fifo_rd_data;

    logic [7:0] txq [0:63];
    logic [7:0] rxq [0:63];
    int tx_wr = 0, tx_rd = 0, rx_n = 0;
    int nchk = 0, nfail = 0;

    always #4 clk = ~clk;

    assign fifo_empty   = (tx_rd >= tx_wr);
    assign fifo_rd_data = txq[tx_rd % 64];

    always @(posedge clk) begin
        if (fifo_rd) tx_rd <= tx_rd + 1;
        if (fifo_wr) begin
            rxq[rx_n % 64] <= fifo_wr_data;
            rx_n <= rx_n + 1;
        end
    end

    sd_data_path u_sd_data_path (
        .clk(clk), .rst(rst), .start(start), .dir_rx(dir_rx), .stream_mode(stream_mode),
        .enable(enable), .blk_len(blk_len), .data_len(data_len), .timeout_val(timeout_val),
        .fifo_rd_data(fifo_rd_data), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
        .fifo_wr(fifo_wr), .fifo_wr_data(fifo_wr_data), .fifo_full(fifo_full),
        .dat_in(dat_in), .dat_out(dat_out), .dat_oe(dat_oe), .active(active),
        .timeout_flag(timeout_flag), .crc_fail(crc_fail), .fifo_err(fifo_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] crc_of(input logic [7:0] b [4], input int n);
        logic [15:0] c = 16'h0;
        for (int i = 0; i < n; i++)
            for (int k = 7; k >= 0; k--)
                c = {c[14:0], 1'b0} ^ ((c[15] ^ b[i][k]) ? 16'h1021 : 16'h0);
        return c;
    endfunction

    task automatic push(input logic [7:0] b);
        txq[tx_wr % 64] = b;
        tx_wr++;
    endtask

    task automatic go(input logic rx, input logic strm, input int blk, input int len, input int tmo);
        dir_rx = rx; stream_mode = strm; blk_len = 12'(blk);
        data_len = 16'(len); timeout_val = 16'(tmo);
        start = 1;
        tick(1);
        start = 0;
    endtask

    task automatic cap_tx(output logic [63:0] bits, output int n);
        int guard = 0;
        bits = '0; n = 0;
        while (!dat_oe && guard < 200) begin tick(1); guard++; end
        while (dat_oe && n < 64) begin
            bits = {bits[62:0], dat_out};
            n++;
            tick(1);
        end
    endtask

    task automatic wait_idle(input string tag);
        int guard = 0;
        while (active && guard < 500) begin tick(1); guard++; end
        chk(tag, active, 0);
    endtask

    task automatic send_token(input logic [2:0] t, input int busy);
        dat_in = 1; tick(2);
        dat_in = 0; tick(1);
        for (int k = 2; k >= 0; k--) begin dat_in = t[k]; tick(1); end
        dat_in = 1; tick(1);
        dat_in = 0; tick(busy);
        dat_in = 1; tick(2);
    endtask

    task automatic card_frame(input logic [7:0] b [4], input int n, input logic with_crc,
                              input logic flip);
        logic [15:0] c;
        c = crc_of(b, n) ^ {15'b0, flip};
        dat_in = 1; tick(2);
        dat_in = 0; tick(1);
        for (int i = 0; i < n; i++)
            for (int k = 7; k >= 0; k--) begin dat_in = b[i][k]; tick(1); end
        if (with_crc)
            for (int k = 15; k >= 0; k--) begin dat_in = c[k]; tick(1); end
        dat_in = 1; tick(2);
    endtask

    task automatic t_reset();
        chk("R1 reset active", active, 0);
        chk("R1 reset oe/out", {dat_oe, dat_out}, 2'b01);
        chk("R1 reset strobes", {fifo_rd, fifo_wr}, 0);
        chk("R1 reset flags", {timeout_flag, crc_fail, fifo_err}, 0);
    endtask

    task automatic t_tx_block();
        logic [7:0] b [4] = '{8'hA5, 8'h3C, 8'h00, 8'h00};
        logic [63:0] bits; int n;
        push(8'hA5); push(8'h3C);
        go(0, 0, 2, 2, 1000);
        chk("R1 active after start", active, 1);
        chk("R7 wait cycle 1", dat_oe, 0);
        tick(1);
        chk("R7 wait cycle 2", dat_oe, 0);
        tick(1);
        chk("R7 start bit after two waits", {dat_oe, dat_out}, 2'b10);
        cap_tx(bits, n);
        chk("R8 block bit count", 64'(n), 34);
        chk("R8 block frame", bits, {30'b0, 1'b0, 8'hA5, 8'h3C, crc_of(b, 2), 1'b1});
        send_token(3'b010, 3);
        wait_idle("R11 positive token completes");
        chk("R11 no flags", {timeout_flag, crc_fail, fifo_err}, 0);
    endtask

    task automatic t_tx_wait_empty();
        logic [7:0] b [4] = '{8'h81, 8'h00, 8'h00, 8'h00};
        logic [63:0] bits; int n;
        go(0, 0, 1, 1, 1000);
        tick(6);
        chk("R7 held while empty", {active, dat_oe}, 2'b10);
        push(8'h81);
        tick(1);
        chk("R7 send after non-empty", {dat_oe, dat_out}, 2'b10);
        cap_tx(bits, n);
        chk("R8 single byte frame", bits, {38'b0, 1'b0, 8'h81, crc_of(b, 1), 1'b1});
        send_token(3'b101, 2);
        wait_idle("R11 negative token ends");
        chk("R11 crc_fail on 101", crc_fail, 1);
    endtask

    task automatic t_busy_timeout();
        logic [63:0] bits; int n;
        push(8'h5E);
        go(0, 0, 1, 1, 20);
        chk("R1 start clears flags", crc_fail, 0);
        cap_tx(bits, n);
        tick(19);
        chk("R12 busy wait still active", active, 1);
        tick(1);
        chk("R12 busy timeout idle", active, 0);
        chk("R12 busy timeout flag", timeout_flag, 1);
    endtask

    task automatic t_tx_stream();
        logic [63:0] bits; int n;
        push(8'h11); push(8'h22); push(8'h33); push(8'h44);
        enable = 0;
        go(0, 1, 1, 4, 1000);
        cap_tx(bits, n);
        chk("R9 enable low stops after byte", 64'(n), 9);
        chk("R9 first byte", bits, {55'b0, 1'b0, 8'h11});
        chk("R9 idle after enable low", active, 0);
        enable = 1;
        go(0, 1, 1, 3, 1000);
        cap_tx(bits, n);
        chk("R9 stream bit count", 64'(n), 25);
        chk("R9 stream bits", bits, {39'b0, 1'b0, 8'h22, 8'h33, 8'h44});
        chk("R9 stream done", {active, timeout_flag, crc_fail, fifo_err}, 0);
    endtask

    task automatic t_underrun();
        logic [63:0] bits; int n;
        push(8'hC7);
        go(0, 1, 1, 3, 1000);
        cap_tx(bits, n);
        chk("R10 bits before underrun", 64'(n), 9);
        chk("R10 underrun flag/idle", {active, fifo_err}, 2'b01);
    endtask

    task automatic t_rx_block(input logic flip);
        logic [7:0] b [4] = '{8'h5A, 8'hC3, 8'h00, 8'h00};
        int base = rx_n;
        go(1, 0, 2, 2, 200);
        card_frame(b, 2, 1, flip);
        wait_idle("R2 receive ends at zero count");
        chk("R3 two bytes written", 64'(rx_n - base), 2);
        chk("R3 bytes MSB first", {rxq[base % 64], rxq[(base + 1) % 64]}, 16'h5AC3);
        chk(flip ? "R4 crc mismatch flag" : "R4 crc match no flag", crc_fail, flip);
        chk("R12 no timeout on receive", timeout_flag, 0);
    endtask

    task automatic t_rx_stream();
        logic [7:0] b [4] = '{8'h0F, 8'hF0, 8'h96, 8'h00};
        int base = rx_n;
        go(1, 1, 1, 3, 200);
        card_frame(b, 3, 0, 0);
        wait_idle("R5 stream receive ends");
        chk("R5 three bytes", 64'(rx_n - base), 3);
        chk("R5 stream data",
            {rxq[base % 64], rxq[(base + 1) % 64], rxq[(base + 2) % 64]}, 24'h0FF096);
        chk("R5 no flags", {timeout_flag, crc_fail, fifo_err}, 0);
    endtask

    task automatic t_overrun();
        logic [7:0] b [4] = '{8'hE1, 8'h00, 8'h00, 8'h00};
        int base = rx_n;
        fifo_full = 1;
        go(1, 1, 1, 1, 200);
        card_frame(b, 1, 0, 0);
        wait_idle("R6 overrun returns idle");
        chk("R6 no byte written", 64'(rx_n - base), 0);
        chk("R6 fifo_err only", {timeout_flag, fifo_err}, 2'b01);
        fifo_full = 0;
    endtask

    task automatic t_rx_timeout();
        dat_in = 1;
        go(1, 0, 1, 1, 10);
        tick(9);
        chk("R12 wait still active", active, 1);
        tick(1);
        chk("R12 receive timeout idle", active, 0);
        chk("R12 receive timeout flag", timeout_flag, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        tick(3);
        rst = 0;
        tick(1);
        t_reset();
        t_tx_block();
        t_tx_wait_empty();
        t_busy_timeout();
        t_tx_stream();
        t_underrun();
        t_rx_block(0);
        t_rx_block(1);
        t_rx_stream();
        t_overrun();
        t_rx_timeout();
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule